// File: doc/BRIEF.md
# GPIO Edge Interrupt Bank

This block watches a bank of general-purpose input lines and turns selected transitions on them into one interrupt for a host. Each line passes through a two-stage synchroniser. Edges are found by comparing the synchronised value with its value one cycle earlier. Every line has a two-bit edge selector and a blocking bit. An edge that is selected and not blocked sets a sticky pending bit for that line. The pending bits stay set until the host acknowledges them.

The host reaches the block through a small register port. Writes take effect on the next clock edge. Read data is combinational from the address. A typical host reacts to the falling edge of the active-low interrupt, reads the pending register, and writes the same value back to acknowledge. An optional side path also clears all pending bits whenever the host reads the synchronised pin value. One control bit switches this path off.

Top module: `edge_irq_bank`

## Requirements
- R1: After reset the block register (address 1) reads all ones, so every line is blocked. The edge-select register (address 2), the pending register (address 3) and the control register (address 4) read zero, and `irq_n` is high.
- R2: For line n, edge-select bit 2n enables rising-edge detection. With only that bit set, a 0-to-1 transition sets pending bit n and a 1-to-0 transition does not.
- R3: For line n, edge-select bit 2n+1 enables falling-edge detection. With only that bit set, a 1-to-0 transition sets pending bit n and a 0-to-1 transition does not.
- R4: With both selector bits of a line set, either transition sets its pending bit. With selector value 00, neither transition does. No level on a line ever sets a pending bit.
- R5: While block bit n is 1, no edge on line n sets pending bit n. Clearing the block bit to 0 lets edges through.
- R6: A write to the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. No other write and no read (except as in R9) clears a pending bit.
- R7: If a selected edge and a write of 1 hit the same pending bit in the same cycle, the bit stays set.
- R8: `irq_n` is a register. It is low in the cycle after any pending bit is set and high in the cycle after all pending bits are clear.
- R9: While control bit 0 (address 4) is 0, a read of the pin-data register (address 0) clears all pending bits at that clock edge. While it is 1, such a read leaves the pending bits unchanged.
- R10: The pin-data register (address 0) returns the input lines, delayed by two clock edges of synchronisation, in its low LINES bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | LINES | Raw input lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (for the read side effect) |
| addr | input | AW | Register address |
| wr_data | input | 2*LINES | Write data |
| rd_data | output | 2*LINES | Read data, combinational from `addr` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Edge detection is tried on a table of single-line transitions, one row per line. The rows cover rising and falling transitions under every selector value and under a set block bit. Each row is expected either to set the pending bit or to leave it clear, so a swapped selector bit, a direction inversion or an ignored block bit shows up as a mismatch. Separate directed sequences cover the other behaviour. One clears part of a multi-bit pending pattern, which separates per-bit write-1 clearing from whole-register clearing. One lands an acknowledge in the exact cycle a new edge arrives, which shows whether the edge takes priority. Pin-data reads are made with the auto-clear path both on and off.

// File: rtl/edge_irq_bank.sv
module edge_irq_bank #(
  parameter int LINES = 16,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pins_i,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [2*LINES-1:0] wr_data,
  output logic [2*LINES-1:0] rd_data,
  output logic             irq_n
);
  localparam int DW = 2 * LINES;
  localparam logic [AW-1:0] A_PIN = AW'(0), A_BLK = AW'(1), A_SEL = AW'(2),
                            A_PEND = AW'(3), A_CTL = AW'(4);

  logic [LINES-1:0] sync1, sync2, prev, blk, pend, hit, clr;
  logic [DW-1:0]    sel;
  logic             keep;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; prev <= '0;
    end else begin
      sync1 <= pins_i; sync2 <= sync1; prev <= sync2;
    end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign hit[i] = ~blk[i] & ((sel[2*i]   &  sync2[i] & ~prev[i]) |
                               (sel[2*i+1] & ~sync2[i] &  prev[i]));
  end

  assign clr = ((wr_en && addr == A_PEND) ? wr_data[LINES-1:0] : '0) |
               ((rd_en && addr == A_PIN && !keep) ? {LINES{1'b1}} : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      blk <= '1; sel <= '0; keep <= 1'b0; pend <= '0; irq_n <= 1'b1;
    end else begin
      if (wr_en && addr == A_BLK) blk  <= wr_data[LINES-1:0];
      if (wr_en && addr == A_SEL) sel  <= wr_data;
      if (wr_en && addr == A_CTL) keep <= wr_data[0];
      pend  <= (pend & ~clr) | hit;
      irq_n <= ~(|pend);
    end

  always_comb
    case (addr)
      A_PIN:   rd_data = {{(DW-LINES){1'b0}}, sync2};
      A_BLK:   rd_data = {{(DW-LINES){1'b0}}, blk};
      A_SEL:   rd_data = sel;
      A_PEND:  rd_data = {{(DW-LINES){1'b0}}, pend};
      A_CTL:   rd_data = {{(DW-1){1'b0}}, keep};
      default: rd_data = '0;
    endcase

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (blk == '1 && sel == '0 && pend == '0 && irq_n));

  assert_blocked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk != '0) |=> ((pend & ~$past(pend) & $past(blk)) == '0));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_PEND) && !(rd_en && addr == A_PIN && !keep)
      |=> ((pend & $past(pend)) == $past(pend)));

  assert_irq_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |=> !irq_n);

  assert_irq_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend) |=> irq_n);
endmodule

// File: tb/edge_irq_bank_test.sv
module edge_irq_bank_test;
  localparam int CLK = 10;
  localparam int L = 16;
  localparam int DW = 2 * L;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, irq_n;
  logic [L-1:0] pins = '0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  int checks = 0, fails = 0;

  edge_irq_bank #(.LINES(L), .AW(3)) uut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wdata), .rd_data(rdata), .irq_n(irq_n));

  always #(CLK/2) clk = ~clk;

  // {sel[1:0], blocked, from, to, expect}
  localparam logic [5:0] VEC [8] = '{
    6'b01_0_01_1, 6'b01_0_10_0, 6'b10_0_10_1, 6'b10_0_01_0,
    6'b11_0_01_1, 6'b11_0_10_1, 6'b00_0_01_0, 6'b11_1_01_0};
  string tags [8] = '{"R2", "R2", "R3", "R3", "R4", "R4", "R4", "R5"};

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [DW-1:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [DW-1:0] d);
    rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    idle(3); rst_n = 1; @(negedge clk);

    rd(3'd1, d); chk("R1 block reg", d, 32'h0000_FFFF);
    rd(3'd2, d); chk("R1 select reg", d, '0);
    rd(3'd3, d); chk("R1 pending reg", d, '0);
    rd(3'd4, d); chk("R1 control reg", d, '0);
    chk("R1 irq_n", DW'(irq_n), 1);

    pins = 16'hA5C3; idle(3);
    rd(3'd0, d); chk("R10 pin data", d, 32'h0000_A5C3);
    pins = '0; idle(4);

    for (int i = 0; i < 8; i++) begin
      logic [5:0] v;
      v = VEC[i];
      pins = v[2] ? L'(1) << i : '0; idle(4);
      wr(3'd2, DW'(v[5:4]) << (2 * i));
      wr(3'd1, v[3] ? 32'hFFFF : DW'(~(L'(1) << i)));
      wr(3'd3, 32'hFFFF);
      pins = v[1] ? L'(1) << i : '0; idle(5);
      rd(3'd3, d); chk(tags[i], d, DW'(v[0]) << i);
      chk(tags[i], DW'(irq_n), DW'(!v[0]));
      wr(3'd1, 32'hFFFF); wr(3'd2, '0); wr(3'd3, 32'hFFFF);
      pins = '0; idle(4);
    end

    // R6 / R8: partial write-1 clear
    wr(3'd2, 32'h0000_0055); wr(3'd1, 32'hFFF0);
    pins = 16'h000F; idle(5);
    rd(3'd3, d); chk("R6 pending set", d, 32'h0000_000F);
    chk("R8 irq low", DW'(irq_n), 0);
    wr(3'd3, 32'h0005); idle(1);
    rd(3'd3, d); chk("R6 partial clear", d, 32'h0000_000A);
    chk("R8 irq still low", DW'(irq_n), 0);
    wr(3'd3, 32'h000A); idle(2);
    rd(3'd3, d); chk("R6 full clear", d, '0);
    chk("R8 irq high", DW'(irq_n), 1);

    // R7: edge lands in the same cycle as the acknowledge
    wr(3'd2, 32'h0000_0003); wr(3'd1, 32'hFFFE);
    pins = 16'h0000; idle(5); wr(3'd3, 32'hFFFF);
    pins = 16'h0001; idle(5);
    rd(3'd3, d); chk("R7 setup", d, 32'h1);
    pins = 16'h0000; idle(2); wr(3'd3, 32'h0001);
    rd(3'd3, d); chk("R7 edge wins", d, 32'h1);

    // R9: auto clear on pin-data read
    rd(3'd0, d); idle(1);
    rd(3'd3, d); chk("R9 cleared by data read", d, '0);
    wr(3'd4, 32'h1);
    pins = 16'h0001; idle(5);
    rd(3'd0, d); idle(1);
    rd(3'd3, d); chk("R9 kept when disabled", d, 32'h1);
    chk("R8 irq held", DW'(irq_n), 0);

    finish_run();
  end
endmodule